// File: doc/BRIEF.md
# Streaming Block Transpose for a Separable 2-D Transform

This block sits between the first (row) and second (column) one-dimensional transform of an N x N separable two-dimensional transform, N = 8 by default. On every accepted cycle it takes in one row of N coefficients. For each complete block it hands the second transform one N-wide column per clock. The reordering uses no RAM. Each lane of the input vector passes through its own delay line, and lane j is j cycles longer than lane 0. In any cycle the lanes therefore carry coefficients of N different input rows, and no input vector is read at more than one position at a time. A per-lane collector gathers the diagonally arriving coefficients into a complete column. An output selector then presents those columns one after the other.

The stream is continuous. Blocks may follow each other with no idle cycle in between, and the output columns of one block come out while the next block is already entering. An input flag marks the first row of a block and restarts the row count. An output flag marks the first column of each transposed block.

Top module: `tp_skew_transpose`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `out_sob` are low and `out_col` is zero.
- R2: A row is accepted on a rising edge where `in_valid` is high. The row index starts at 0 after reset. It is forced to 0 when `in_sob` is high on an accepted row and otherwise increases by one per accepted row, wrapping from N-1 back to 0. A block therefore also starts without `in_sob` once N rows have wrapped.
- R3: Element k of a vector occupies bits [k*W +: W]. In the output column j of a block, element i equals element j of the block's input row i.
- R4: If input row N-1 of a block is accepted on edge n, column j is presented after edge n+1+j for one cycle, for j = 0..N-1. `out_valid` is high in exactly those cycles and low in every other cycle.
- R5: `out_sob` is high together with column 0 of each block and low in every other cycle.
- R6: Blocks sent back to back with no idle cycle are all transposed correctly, and the N columns of each block appear on N consecutive cycles.
- R7: Cycles with `in_valid` low do not advance the row index, and the data and `in_sob` presented on them have no effect. A block whose rows are spread over gaps is transposed exactly like a gapless one.
- R8: If `in_sob` arrives on an accepted row before a block is complete, the partial block is dropped and produces no output columns. The new block starts at row index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row is present this cycle |
| in_sob | input | 1 | Input row is row 0 of a new block |
| in_row | input | N*W | Input row, element k at [k*W +: W] |
| out_valid | output | 1 | Output column is present this cycle |
| out_sob | output | 1 | Output column is column 0 of a block |
| out_col | output | N*W | Output column, element i at [i*W +: W] |

## Verification
On every cycle the assertions enforce the reset state, a fixed two-edge distance from the acceptance of a block's last row to its first column with the start flag, and the framing of the output. That framing means N contiguous valid cycles per block with the start flag on the first of them only. Whether each coefficient lands at the right place, and whether gapped, wrapped and aborted blocks give the right columns, is shown by the bench's scenarios. The bench compares every cycle against a software transpose scheduled from the accepted rows.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // default geometry of the transpose
  parameter int unsigned TP_N_DEF = 8;
  parameter int unsigned TP_W_DEF = 16;

  function automatic int unsigned tp_idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tp_row_counter.sv
module tp_row_counter #(
  parameter int unsigned N  = tp_pkg::TP_N_DEF,
  parameter int unsigned RW = tp_pkg::tp_idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          restart,
  output logic [RW-1:0] row_idx
);
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic [RW-1:0] cnt_q;

  // index of the row offered this cycle
  assign row_idx = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (acc) begin
      cnt_q <= (row_idx == LAST) ? '0 : row_idx + RW'(1);
    end
  end
endmodule

// File: rtl/tp_skew_lane.sv
module tp_skew_lane #(
  parameter int unsigned DEPTH = 1,
  parameter int unsigned W     = tp_pkg::TP_W_DEF,
  parameter int unsigned RW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [RW-1:0] row_i,
  input  logic [W-1:0]  d_i,
  output logic          v_o,
  output logic [RW-1:0] row_o,
  output logic [W-1:0]  d_o
);
  logic          v_q   [DEPTH];
  logic [RW-1:0] row_q [DEPTH];
  logic [W-1:0]  d_q   [DEPTH];

  // qualifier stages carry reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) v_q[k] <= 1'b0;
    end else begin
      v_q[0] <= v_i;
      for (int k = 1; k < DEPTH; k++) v_q[k] <= v_q[k-1];
    end
  end

  // payload stages need no reset
  always_ff @(posedge clk) begin
    row_q[0] <= row_i;
    d_q[0]   <= d_i;
    for (int k = 1; k < DEPTH; k++) begin
      row_q[k] <= row_q[k-1];
      d_q[k]   <= d_q[k-1];
    end
  end

  assign v_o   = v_q[DEPTH-1];
  assign row_o = row_q[DEPTH-1];
  assign d_o   = d_q[DEPTH-1];
endmodule

// File: rtl/tp_column_collector.sv
module tp_column_collector #(
  parameter int unsigned N = tp_pkg::TP_N_DEF,
  parameter int unsigned W = tp_pkg::TP_W_DEF
) (
  input  logic           clk,
  input  logic           lane_v,
  input  logic [W-1:0]   lane_d,
  output logic [N*W-1:0] col
);
  // hist[i] holds the coefficient of row i once N-1 rows have passed
  logic [W-1:0] hist [N-1];

  always_ff @(posedge clk) begin
    if (lane_v) begin
      for (int k = 0; k < int'(N) - 2; k++) hist[k] <= hist[k+1];
      hist[N-2] <= lane_d;
    end
  end

  generate
    for (genvar i = 0; i < int'(N) - 1; i++) begin : g_pack
      assign col[i*W +: W] = hist[i];
    end
  endgenerate
  assign col[(N-1)*W +: W] = lane_d;
endmodule

// File: rtl/tp_skew_transpose.sv
module tp_skew_transpose #(
  parameter int unsigned N = tp_pkg::TP_N_DEF,
  parameter int unsigned W = tp_pkg::TP_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_sob,
  input  logic [N*W-1:0] in_row,
  output logic           out_valid,
  output logic           out_sob,
  output logic [N*W-1:0] out_col
);
  localparam int unsigned   RW   = tp_pkg::tp_idx_bits(N);
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic [RW-1:0]  row_idx;
  logic           lane_v   [N];
  logic [RW-1:0]  lane_row [N];
  logic [W-1:0]   lane_d   [N];
  logic [N*W-1:0] lane_col [N];
  logic [N-1:0]   done;
  logic [N*W-1:0] sel_col;

  tp_row_counter #(.N(N), .RW(RW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .acc     (in_valid),
    .restart (in_sob),
    .row_idx (row_idx)
  );

  // lane j is skewed by j cycles relative to lane 0
  generate
    for (genvar j = 0; j < int'(N); j++) begin : g_lane
      tp_skew_lane #(.DEPTH(j + 1), .W(W), .RW(RW)) u_skew (
        .clk   (clk),
        .rst   (rst),
        .v_i   (in_valid),
        .row_i (row_idx),
        .d_i   (in_row[j*W +: W]),
        .v_o   (lane_v[j]),
        .row_o (lane_row[j]),
        .d_o   (lane_d[j])
      );

      tp_column_collector #(.N(N), .W(W)) u_coll (
        .clk    (clk),
        .lane_v (lane_v[j]),
        .lane_d (lane_d[j]),
        .col    (lane_col[j])
      );

      assign done[j] = lane_v[j] && (lane_row[j] == LAST);
    end
  endgenerate

  // realignment: at most one lane completes a column per cycle
  always_comb begin
    sel_col = '0;
    for (int j = 0; j < int'(N); j++) begin
      if (done[j]) sel_col = sel_col | lane_col[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_col   <= '0;
    end else begin
      out_valid <= |done;
      out_sob   <= done[0];
      out_col   <= sel_col;
    end
  end
endmodule

// File: rtl/tp_skew_transpose_chk.sv
module tp_skew_transpose_chk #(
  parameter int unsigned N = tp_pkg::TP_N_DEF
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_sob,
  input logic out_valid,
  input logic out_sob
);
  localparam int unsigned   RW   = tp_pkg::tp_idx_bits(N);
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic [RW-1:0] icnt_q;
  logic [RW-1:0] irow;
  logic [RW-1:0] ocnt_q;

  assign irow = in_sob ? '0 : icnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt_q <= '0;
      ocnt_q <= '0;
    end else begin
      if (in_valid) icnt_q <= (irow == LAST) ? '0 : irow + RW'(1);
      if (out_valid) ocnt_q <= (ocnt_q == LAST) ? '0 : ocnt_q + RW'(1);
    end
  end

  // R1: output idle in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sob));

  // R4: last row accepted -> first column two edges later
  a_r4_first_column_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && irow == LAST) |-> ##2 (out_valid && out_sob));

  // R5: start flag only with column 0
  a_r5_sob_on_first: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sob == (ocnt_q == '0)));

  // R5: start flag never without valid
  a_r5_sob_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_sob |-> out_valid);

  // R6: columns of a block are contiguous
  a_r6_contiguous_columns: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ocnt_q != LAST) |=> out_valid);
endmodule

bind tp_skew_transpose tp_skew_transpose_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sob    (in_sob),
  .out_valid (out_valid),
  .out_sob   (out_sob)
);

// File: tb/tp_skew_transpose_tb_top.sv
module tp_skew_transpose_tb_top;
  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_sob = 1'b0;
  logic [N*W-1:0] in_row = '0;
  logic           out_valid;
  logic           out_sob;
  logic [N*W-1:0] out_col;

  always #10 clk = ~clk;

  tp_skew_transpose #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob), .in_row(in_row),
    .out_valid(out_valid), .out_sob(out_sob), .out_col(out_col)
  );

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1 reset";

  logic [N*W-1:0] exp_d [int];
  bit             exp_s [int];
  logic [W-1:0]   blk [N][N];
  int             mrow = 0;

  // behavioural reference: record rows, schedule the transposed block
  always @(posedge clk) begin
    int r;
    logic [N*W-1:0] v;
    cyc = cyc + 1;
    if (rst) begin
      mrow = 0;
    end else if (in_valid) begin
      r = in_sob ? 0 : mrow;
      for (int k = 0; k < N; k++) blk[r][k] = in_row[k*W +: W];
      if (r == N - 1) begin
        for (int j = 0; j < N; j++) begin
          for (int i = 0; i < N; i++) v[i*W +: W] = blk[i][j];
          exp_d[cyc + 1 + j] = v;
          exp_s[cyc + 1 + j] = (j == 0);
        end
      end
      mrow = (r + 1) % N;
    end
  end

  task automatic chk(string req, logic [N*W-1:0] act, logic [N*W-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s [%s] cycle %0d: actual %h expected %h", req, phase, cyc, act, expv);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      if (rst || exp_d.size() == 0 && phase == "R1 reset") begin
        chk("R1", {{(N*W-2){1'b0}}, out_valid, out_sob}, '0);
        chk("R1", out_col, '0);
      end else if (exp_d.exists(cyc)) begin
        chk("R4", {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, 1'b1});
        chk("R3", out_col, exp_d[cyc]);
        chk("R5", {{(N*W-1){1'b0}}, out_sob}, {{(N*W-1){1'b0}}, exp_s[cyc]});
      end else begin
        chk("R4", {{(N*W-2){1'b0}}, out_valid, out_sob}, '0);
      end
    end
  end

  function automatic logic [N*W-1:0] rnd();
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = W'($urandom);
    return r;
  endfunction

  task automatic send_row(bit sob);
    @(negedge clk);
    in_valid = 1'b1;
    in_sob   = sob;
    in_row   = rnd();
  endtask

  // idle cycles carry garbage that must be ignored (R7)
  task automatic idle(int k);
    for (int c = 0; c < k; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sob   = 1'($urandom);
      in_row   = rnd();
    end
  endtask

  task automatic send_block(bit sob, int max_gap);
    for (int r = 0; r < N; r++) begin
      send_row(sob && r == 0);
      if (max_gap > 0) idle($urandom % (max_gap + 1));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);  // R1: first cycle after reset still idle
    phase = "R6 back-to-back";
    for (int b = 0; b < 3; b++) send_block(1'b1, 0);
    phase = "R2 wrap without start flag";
    send_block(1'b0, 0);
    send_block(1'b1, 0);
    phase = "R7 gapped rows";
    for (int b = 0; b < 3; b++) send_block(1'b1, 2);
    idle(4);
    phase = "R8 aborted block";
    for (int r = 0; r < 5; r++) send_row(r == 0);
    send_block(1'b1, 0);
    for (int r = 0; r < 3; r++) send_row(r == 0);
    idle(2);
    send_block(1'b1, 1);
    phase = "R6 drain";
    idle(3 * N);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule